// File: doc/BRIEF.md
# Cascaded Quad-DAC Serial Update Controller

This controller sits on the host side of a serial link to a chain of quad 12-bit DACs. The DACs share one serial clock and one enable/load strobe. Each device passes its shift-register output to the data input of the next device. The controller takes one 12-bit code for every channel of every device and converts the whole set into a single serial stream. It drives the clock, data and strobe lines with minimum widths and separations set as counts of system-clock cycles. It finishes by raising the strobe once, so every device in the chain loads its new codes at the same instant.

A transfer starts with a single-cycle `start_i` while the block is idle. `busy_o` stays high until the strobe pulse has ended. While the new stream goes out, the controller samples the serial output returning from the far end of the chain. When `busy_o` falls, `rdata_o` holds the codes the chain held before the transfer. `rdata_o` uses the same layout as `codes_i`.

Top module: `dac_chain_master`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `ld_o` is 1 and `sclk_o` is 0. Reset also clears `busy_o` and `rdata_o` to 0.
- R2: A `start_i` sampled while idle makes `busy_o` and a low `ld_o` appear on the next cycle. `busy_o` then stays high for exactly NUM_DEV*48*(LO_CYC+HI_CYC)+TAIL_CYC+LDW_CYC cycles and falls with `ld_o` high.
- R3: A `start_i` sampled while `busy_o` is high is ignored. The transfer in progress keeps its codes and its length, and `ld_o` does not fall again before `busy_o` drops.
- R4: Each transfer gives exactly NUM_DEV*48 rising edges on `sclk_o`. `sclk_o` never rises while `ld_o` is high.
- R5: The code for device d (0 = device wired to `sdo_o`) and channel c (0..3 for channels A..D) sits in `codes_i[(d*4+c)*12 +: 12]`. The stream sends device NUM_DEV-1 first and device 0 last. Within each device it sends channel A, then B, C and D, each MSB first. After the strobe rises, every device holds the codes it was given.
- R6: `sclk_o` stays high at least HI_CYC cycles and low at least LO_CYC cycles. `sdo_o` changes only on a falling `sclk_o` edge or when `ld_o` falls, so it is stable for at least LO_CYC cycles before each rise.
- R7: The first `sclk_o` rise comes at least LO_CYC cycles after `ld_o` falls. `ld_o` rises at least HI_CYC+TAIL_CYC cycles after the last `sclk_o` rise. `ld_o` stays high at least LDW_CYC cycles.
- R8: `sdi_i` is sampled on the cycle in which `sclk_o` rises, and `rdata_o` changes only then. When `busy_o` falls, `rdata_o` holds, in the layout of R5, the codes the chain held before the transfer.
- R9: `sclk_o` is low, and was low on the previous cycle, whenever `ld_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a chain update (single cycle, honoured when idle) |
| codes_i | input | NUM_DEV*48 | Channel codes, layout per R5 |
| busy_o | output | 1 | Transfer in progress, through the end of the strobe pulse |
| rdata_o | output | NUM_DEV*48 | Codes read back from the chain, layout per R5 |
| sclk_o | output | 1 | Shared serial clock |
| sdo_o | output | 1 | Serial data to the first device |
| ld_o | output | 1 | Shared enable/load strobe, high when idle |
| sdi_i | input | 1 | Serial data returned by the last device |

## Verification
The assertions assume that `start_i` and `codes_i` are synchronous to `clk_i`. They also assume that the returning `sdi_i` settles within (HI_CYC+LO_CYC) system cycles of the `sclk_o` rise that shifts it, and never moves exactly on a `clk_i` edge. The bench changes inputs only on falling system-clock edges. Its chain model delays the returned bit by 135 ns, which is less than the 200 ns clock period of the default settings and is not a multiple of the 10 ns half period. Independent ns-resolution monitors check the line timing.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned DEV_CH  = 4;
  localparam int unsigned FRAME_W = CODE_W * DEV_CH;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_PULSE
  } seq_st_e;
endpackage

// File: rtl/dac_chain_remap.sv
// Swaps between the port layout (channel A in the low slice of a device)
// and the wire layout (channel A in the high slice). The permutation is
// its own inverse, so one module serves both directions.
module dac_chain_remap
  import dac_chain_pkg::*;
#(
  parameter int unsigned NUM_DEV = 2
) (
  input  logic [NUM_DEV*FRAME_W-1:0] in_i,
  output logic [NUM_DEV*FRAME_W-1:0] out_o
);
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    for (genvar c = 0; c < DEV_CH; c++) begin : g_ch
      assign out_o[d*FRAME_W + (DEV_CH-1-c)*CODE_W +: CODE_W] =
             in_i[(d*DEV_CH + c)*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/dac_chain_seq.sv
module dac_chain_seq
  import dac_chain_pkg::*;
#(
  parameter int unsigned TOT_W    = 96,
  parameter int unsigned HI_CYC   = 2,
  parameter int unsigned LO_CYC   = 8,
  parameter int unsigned TAIL_CYC = 2,
  parameter int unsigned LDW_CYC  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOT_W-1:0] stream_i,
  input  logic             sdi_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             ld_o,
  output logic [TOT_W-1:0] capt_o
);
  localparam int unsigned MAX_A  = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int unsigned MAX_B  = (TAIL_CYC > LDW_CYC) ? TAIL_CYC : LDW_CYC;
  localparam int unsigned MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TMR_W  = $clog2(MAX_C + 1);
  localparam int unsigned BIT_W  = $clog2(TOT_W);
  localparam logic [TMR_W-1:0] HI_L   = TMR_W'(HI_CYC - 1);
  localparam logic [TMR_W-1:0] LO_L   = TMR_W'(LO_CYC - 1);
  localparam logic [TMR_W-1:0] TAIL_L = TMR_W'(TAIL_CYC - 1);
  localparam logic [TMR_W-1:0] LDW_L  = TMR_W'(LDW_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_B = BIT_W'(TOT_W - 1);

  seq_st_e          st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [BIT_W-1:0] bit_q;
  logic [TOT_W-1:0] sh_q;
  logic [TOT_W-1:0] cap_q;
  logic             sclk_q;
  logic             ld_q;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
      sclk_q <= 1'b0;
      ld_q   <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            sh_q  <= stream_i;
            bit_q <= '0;
            ld_q  <= 1'b0;
            tmr_q <= LO_L;
            st_q  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tmr_zero) begin
            // returning bit has settled since the previous rise
            cap_q  <= {cap_q[TOT_W-2:0], sdi_i};
            sclk_q <= 1'b1;
            tmr_q  <= HI_L;
            st_q   <= ST_HIGH;
          end else begin
            tmr_q <= tmr_q - TMR_W'(1);
          end
        end
        ST_HIGH: begin
          if (tmr_zero) begin
            sclk_q <= 1'b0;
            sh_q   <= {sh_q[TOT_W-2:0], 1'b0};
            if (bit_q == LAST_B) begin
              tmr_q <= TAIL_L;
              st_q  <= ST_TAIL;
            end else begin
              bit_q <= bit_q + BIT_W'(1);
              tmr_q <= LO_L;
              st_q  <= ST_LOW;
            end
          end else begin
            tmr_q <= tmr_q - TMR_W'(1);
          end
        end
        ST_TAIL: begin
          if (tmr_zero) begin
            ld_q  <= 1'b1;
            tmr_q <= LDW_L;
            st_q  <= ST_PULSE;
          end else begin
            tmr_q <= tmr_q - TMR_W'(1);
          end
        end
        ST_PULSE: begin
          if (tmr_zero) st_q <= ST_IDLE;
          else          tmr_q <= tmr_q - TMR_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign sclk_o = sclk_q;
  assign sdo_o  = sh_q[TOT_W-1];
  assign ld_o   = ld_q;
  assign capt_o = cap_q;
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master
  import dac_chain_pkg::*;
#(
  parameter int unsigned NUM_DEV  = 2,
  parameter int unsigned HI_CYC   = 2,
  parameter int unsigned LO_CYC   = 8,
  parameter int unsigned TAIL_CYC = 2,
  parameter int unsigned LDW_CYC  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [NUM_DEV*FRAME_W-1:0] codes_i,
  output logic                       busy_o,
  output logic [NUM_DEV*FRAME_W-1:0] rdata_o,
  output logic                       sclk_o,
  output logic                       sdo_o,
  output logic                       ld_o,
  input  logic                       sdi_i
);
  localparam int unsigned TOT_W = NUM_DEV * FRAME_W;

  logic [TOT_W-1:0] stream;
  logic [TOT_W-1:0] capt;

  dac_chain_remap #(.NUM_DEV(NUM_DEV)) u_pack (
    .in_i  (codes_i),
    .out_o (stream)
  );

  dac_chain_seq #(
    .TOT_W    (TOT_W),
    .HI_CYC   (HI_CYC),
    .LO_CYC   (LO_CYC),
    .TAIL_CYC (TAIL_CYC),
    .LDW_CYC  (LDW_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stream_i (stream),
    .sdi_i    (sdi_i),
    .busy_o   (busy_o),
    .sclk_o   (sclk_o),
    .sdo_o    (sdo_o),
    .ld_o     (ld_o),
    .capt_o   (capt)
  );

  dac_chain_remap #(.NUM_DEV(NUM_DEV)) u_unpack (
    .in_i  (capt),
    .out_o (rdata_o)
  );
endmodule

// File: rtl/dac_chain_master_chk.sv
module dac_chain_master_chk
  import dac_chain_pkg::*;
#(
  parameter int unsigned NUM_DEV  = 2,
  parameter int unsigned HI_CYC   = 2,
  parameter int unsigned LO_CYC   = 8,
  parameter int unsigned TAIL_CYC = 2,
  parameter int unsigned LDW_CYC  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic                       busy_o,
  input logic                       sclk_o,
  input logic                       sdo_o,
  input logic                       ld_o,
  input logic [NUM_DEV*FRAME_W-1:0] rdata_o
);
  localparam logic [15:0] TOT_L  = 16'(NUM_DEV * FRAME_W);
  localparam logic [15:0] HI_L   = 16'(HI_CYC);
  localparam logic [15:0] LO_L   = 16'(LO_CYC);
  localparam logic [15:0] TAIL_L = 16'(HI_CYC + TAIL_CYC);
  localparam logic [15:0] LDW_L  = 16'(LDW_CYC);

  logic [15:0] hi_run, lo_run, ld_lo, since_rise, ld_run, rise_cnt;
  logic        sclk_d;

  function automatic logic [15:0] sat_inc(input logic [15:0] x);
    return (x == 16'hFFFF) ? x : x + 16'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run     <= '0;
      lo_run     <= '0;
      ld_lo      <= '0;
      since_rise <= 16'hFFFF;
      ld_run     <= LDW_L;
      rise_cnt   <= '0;
      sclk_d     <= 1'b0;
    end else begin
      sclk_d     <= sclk_o;
      hi_run     <= sclk_o ? sat_inc(hi_run) : '0;
      lo_run     <= sclk_o ? '0 : sat_inc(lo_run);
      ld_lo      <= ld_o ? '0 : sat_inc(ld_lo);
      ld_run     <= ld_o ? sat_inc(ld_run) : '0;
      since_rise <= (sclk_o && !sclk_d) ? 16'd1 : sat_inc(since_rise);
      if (ld_o)                  rise_cnt <= '0;
      else if (sclk_o && !sclk_d) rise_cnt <= sat_inc(rise_cnt);
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ld_o && !sclk_o));
  p_busy_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && !ld_o));
  p_busy_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ld_o);
  p_no_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !$fell(ld_o));
  p_gated_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |-> !sclk_o);
  p_edge_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_o) |-> (rise_cnt == TOT_L));
  p_sdo_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> (!sclk_o && ($fell(sclk_o) || $fell(ld_o))));
  p_high_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_run >= HI_L));
  p_low_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (lo_run >= LO_L));
  p_lead_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (ld_lo >= LO_L));
  p_tail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_o) |-> (since_rise >= TAIL_L));
  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ld_o) |-> (ld_run >= LDW_L));
  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $rose(sclk_o));
  p_clk_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ld_o) |-> (!sclk_o && !$past(sclk_o)));
endmodule

bind dac_chain_master dac_chain_master_chk #(
  .NUM_DEV  (NUM_DEV),
  .HI_CYC   (HI_CYC),
  .LO_CYC   (LO_CYC),
  .TAIL_CYC (TAIL_CYC),
  .LDW_CYC  (LDW_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .sclk_o  (sclk_o),
  .sdo_o   (sdo_o),
  .ld_o    (ld_o),
  .rdata_o (rdata_o)
);

// File: tb/tb_dac_chain_master.sv
`timescale 1ns/1ps
module tb_dac_chain_master;
  localparam int NDEV = 2;
  localparam int TOT  = NDEV * 48;
  localparam int HI = 2, LO = 8, TAIL = 2, LDW = 3;
  localparam int XLEN = TOT * (LO + HI) + TAIL + LDW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [TOT-1:0] codes_i = '0;
  logic busy_o, sclk_o, sdo_o, ld_o;
  logic [TOT-1:0] rdata_o;
  logic sdi_i;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dac_chain_master #(.NUM_DEV(NDEV), .HI_CYC(HI), .LO_CYC(LO),
                     .TAIL_CYC(TAIL), .LDW_CYC(LDW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .codes_i(codes_i),
    .busy_o(busy_o), .rdata_o(rdata_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .ld_o(ld_o), .sdi_i(sdi_i));

  // chain model: device 0 in chain[47:0], device NDEV-1 drives sdi_i
  logic [TOT-1:0] chain, latched;
  int rises = 0, gated = 0;
  always @(posedge sclk_o) begin
    rises++;
    if (!ld_o) chain <= {chain[TOT-2:0], sdo_o};
    else gated++;
  end
  always @(chain) sdi_i <= #135 chain[TOT-1];
  always @(posedge ld_o) latched <= chain;

  // line timing monitors (ns)
  realtime t_rise = -1.0e6, t_fall = -1.0e6, t_sdo = -1.0e6;
  realtime t_ldf = -1.0e6, t_ldr = -1.0e6;
  int tv_r6 = 0, tv_r7 = 0, tv_r9 = 0;
  always @(posedge sclk_o) begin
    if ($realtime - t_fall < 40.0) tv_r6++;
    if ($realtime - t_sdo < 40.0) tv_r6++;
    if ($realtime - t_ldf < 20.0) tv_r7++;
    t_rise = $realtime;
  end
  always @(negedge sclk_o) begin
    if ($realtime - t_rise < 40.0) tv_r6++;
    t_fall = $realtime;
  end
  always @(sdo_o) t_sdo = $realtime;
  always @(posedge ld_o) begin
    if ($realtime - t_rise < 40.0) tv_r7++;
    if (sclk_o) tv_r9++;
    t_ldr = $realtime;
  end
  always @(negedge ld_o) begin
    if ($realtime - t_ldr < 50.0) tv_r7++;
    if (sclk_o || ($realtime - t_fall < 20.0)) tv_r9++;
    t_ldf = $realtime;
  end

  function automatic logic [TOT-1:0] dev_to_codes(input logic [TOT-1:0] ch);
    logic [TOT-1:0] r = '0;
    for (int d = 0; d < NDEV; d++)
      for (int c = 0; c < 4; c++)
        r[(d*4+c)*12 +: 12] = ch[d*48 + (3-c)*12 +: 12];
    return r;
  endfunction

  function automatic logic [TOT-1:0] rand_vec();
    logic [TOT-1:0] r = '0;
    for (int i = 0; i < TOT; i += 32) r = (r << 32) | TOT'($urandom);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [TOT-1:0] act,
                     input logic [TOT-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [TOT-1:0] c, input bit poke);
    logic [TOT-1:0] snap;
    int n, r0;
    snap = dev_to_codes(chain);
    r0 = rises;
    @(negedge clk_i);
    codes_i = c;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && ld_o === 1'b0, "R2 entry", TOT'({busy_o, ld_o}), TOT'(2'b10));
    n = 0;
    while (busy_o === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk_i);
      start_i = poke && (n == 200);
      if (poke && n == 200) codes_i = ~c;
    end
    start_i = 1'b0;
    chk(n == XLEN, poke ? "R3 length" : "R2 length", TOT'(n), TOT'(XLEN));
    chk(ld_o === 1'b1 && sclk_o === 1'b0, "R1 idle", TOT'({ld_o, sclk_o}), TOT'(2'b10));
    chk(rises - r0 == TOT, "R4 edges", TOT'(rises - r0), TOT'(TOT));
    chk(dev_to_codes(latched) === c, poke ? "R3 codes kept" : "R5 codes",
        dev_to_codes(latched), c);
    chk(rdata_o === snap, "R8 readback", rdata_o, snap);
  endtask

  initial begin
    logic [TOT-1:0] v;
    void'($urandom(32'h5EED_1458));
    chain = rand_vec();
    sdi_i = chain[TOT-1];
    repeat (3) @(negedge clk_i);
    chk(ld_o === 1'b1 && sclk_o === 1'b0 && busy_o === 1'b0, "R1 reset lines",
        TOT'({ld_o, sclk_o, busy_o}), TOT'(3'b100));
    chk(rdata_o === '0, "R1 reset rdata", rdata_o, '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(ld_o === 1'b1 && sclk_o === 1'b0 && busy_o === 1'b0, "R1 idle after reset",
        TOT'({ld_o, sclk_o, busy_o}), TOT'(3'b100));

    xfer('0, 1'b0);
    xfer('1, 1'b0);
    v = '0;
    for (int d = 0; d < NDEV; d++)
      for (int c = 0; c < 4; c++)
        v[(d*4+c)*12 +: 12] = {4'(d), 4'(c), 4'hA};
    xfer(v, 1'b0);                        // R5 distinct per slot
    xfer({TOT/4{4'h5}}, 1'b0);
    xfer(rand_vec(), 1'b1);               // R3 start while busy
    for (int i = 0; i < 14; i++) begin
      xfer(rand_vec(), (i % 5) == 2);
      repeat ($urandom_range(0, 6)) @(negedge clk_i);
    end

    chk(gated == 0, "R4 gated edges", TOT'(gated), '0);
    chk(tv_r6 == 0, "R6 clock/data timing", TOT'(tv_r6), '0);
    chk(tv_r7 == 0, "R7 strobe timing", TOT'(tv_r7), '0);
    chk(tv_r9 == 0, "R9 clock low at strobe edges", TOT'(tv_r9), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule